// File: doc/BRIEF.md
# Add/Subtract Condition Flag Unit

This block works out the arithmetic result and five condition flags for integer add and subtract. The flags are negative, zero, overflow, carry and extend. It also covers the extended add and subtract forms. These take the incoming extend bit as a carry-in or a borrow-in, so a multi-word operation can be chained one word at a time. The unit is purely combinational. An execute stage drives the two operands, an operation code, an operand size and the running extend and zero flags. It takes the result and the new flags back in the same cycle.

Plain subtract can be evaluated on the low byte, the low half-word or the full 32-bit word. The other three operations always work on the full word. The extended forms differ from the plain ones in how they treat zero. A zero result keeps the previous zero flag, and a nonzero result clears it. So after a chain of words, the zero flag reports whether the whole multi-word value is zero.

Top module: `ccgen_flag_unit`

## Requirements
- R1: Operation code 0 (plain add) gives result = opa + opb modulo 2^32. C is the carry out of bit 31, and X equals C.
- R2: For plain add, N is result bit 31 and Z is set when the 32-bit result is zero. V is set when the signed sum of the two operands does not fit in 32 bits.
- R3: Operation code 1 (plain subtract) gives result = opa - opb modulo 2^32, with opa as the destination. C is set when the low `w` bits of opa, read as unsigned, are less than the low `w` bits of opb. X equals C.
- R4: For plain subtract at width `w`, N is result bit w-1 and Z is set when the low `w` result bits are all zero. V is set when the signed difference of the low `w` bits of each operand does not fit in `w` bits.
- R5: Size code 0 selects w=8, code 1 selects w=16, and codes 2 and 3 select w=32. The size input acts only on plain subtract. Operation codes 0, 2 and 3 always work at 32 bits, whatever the size code.
- R6: Operation code 3 (extended subtract) with X in = 1 gives result = opa - opb - 1. C and X are set when opa <= opb unsigned. With X in = 0 it gives opa - opb, and C and X are set when opa < opb.
- R7: Operation code 2 (extended add) with X in = 1 gives result = opa + opb + 1. C and X are set when result <= opb unsigned. With X in = 0 it gives opa + opb, and C and X are set when result < opb.
- R8: For operation codes 2 and 3, Z out is Z in ANDed with (result == 0). For operation codes 0 and 1, the Z in input has no effect.
- R9: For operation codes 0 and 1, the X in input has no effect on the result or on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | Destination operand (minuend / first addend) |
| opb_i | input | 32 | Source operand (subtrahend / second addend) |
| op_i | input | 2 | Operation: 0 add, 1 sub, 2 extended add, 3 extended sub |
| size_i | input | 2 | Subtract width: 0 byte, 1 half-word, 2 or 3 word |
| x_i | input | 1 | Incoming extend flag (carry/borrow in for extended forms) |
| z_prev_i | input | 1 | Previous zero flag, used by the extended forms |
| result_o | output | 32 | Arithmetic result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry/borrow flag |
| x_o | output | 1 | Extend flag, a copy of the carry |

## Verification
The unit holds no state, so a fault can only show as a wrong flag for the operands currently applied, and it shows as soon as the inputs settle. The faults most likely to show up are these:
- The wrong width lane is picked, which makes a sized subtract report flags of the full word.
- The carry-in is let into a plain operation.
- The zero flag is recomputed where it should only be held or cleared.

Each of these changes the flag outputs only for particular operand pairs. For that reason the bench crosses the sign and wrap boundary values with every operation, size and incoming flag combination.

// File: rtl/ccgen_pkg.sv
`timescale 1ns/1ps
package ccgen_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADDX = 2'd2,
    OP_SUBX = 2'd3
  } ccgen_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } ccgen_size_e;

endpackage

// File: rtl/ccgen_addsub.sv
`timescale 1ns/1ps
module ccgen_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o
);

  logic [DATA_W-1:0] cin_ext;

  always_comb begin
    cin_ext = {{(DATA_W-1){1'b0}}, cin_i};
    if (sub_i) res_o = a_i - b_i - cin_ext;
    else       res_o = a_i + b_i + cin_ext;
  end

endmodule

// File: rtl/ccgen_lane_flags.sv
`timescale 1ns/1ps
module ccgen_lane_flags #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] res_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);

  localparam int MSB = LANE_W - 1;

  logic [LANE_W-1:0] ovf_vec;

  always_comb begin
    n_o = res_i[MSB];
    z_o = (res_i == '0);
    if (sub_i) begin
      c_o     = cin_i ? (a_i <= b_i) : (a_i < b_i);
      ovf_vec = (a_i ^ res_i) & (a_i ^ b_i);
    end else begin
      c_o     = cin_i ? (res_i <= b_i) : (res_i < b_i);
      ovf_vec = (b_i ^ res_i) & ~(a_i ^ b_i);
    end
    v_o = ovf_vec[MSB];
  end

  always_comb begin
    // R4
    if (sub_i && !cin_i && (a_i == b_i)) begin
      lane_equal_chk: assert (z_o && !c_o && !v_o)
        else $error("equal operands must subtract to zero with no borrow");
    end
    // R1
    if (!sub_i && !cin_i && (b_i == '0)) begin
      add_zero_chk: assert (!c_o && !v_o)
        else $error("adding zero must not carry or overflow");
    end
  end

endmodule

// File: rtl/ccgen_flag_unit.sv
`timescale 1ns/1ps
module ccgen_flag_unit
  import ccgen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              x_i,
  input  logic              z_prev_i,
  output logic [DATA_W-1:0] result_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              x_o
);

  localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;
  localparam int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam logic [SEL_W-1:0] TOP_LANE = SEL_W'(NUM_LANES - 1);

  ccgen_op_e        op;
  logic             is_sub;
  logic             is_ext;
  logic             cin;
  logic [SEL_W-1:0] lane_sel;

  logic [NUM_LANES-1:0] lane_n;
  logic [NUM_LANES-1:0] lane_z;
  logic [NUM_LANES-1:0] lane_v;
  logic [NUM_LANES-1:0] lane_c;

  always_comb begin
    op     = ccgen_op_e'(op_i);
    is_sub = (op == OP_SUB) || (op == OP_SUBX);
    is_ext = (op == OP_ADDX) || (op == OP_SUBX);
    cin    = is_ext & x_i;
    if ((op == OP_SUB) && (SEL_W'(size_i) < TOP_LANE)) lane_sel = SEL_W'(size_i);
    else                                              lane_sel = TOP_LANE;
  end

  ccgen_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (is_sub),
    .cin_i (cin),
    .res_o (result_o)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = 8 << g;
    ccgen_lane_flags #(.LANE_W(LW)) u_lane (
      .a_i   (opa_i[LW-1:0]),
      .b_i   (opb_i[LW-1:0]),
      .res_i (result_o[LW-1:0]),
      .sub_i (is_sub),
      .cin_i (cin),
      .n_o   (lane_n[g]),
      .z_o   (lane_z[g]),
      .v_o   (lane_v[g]),
      .c_o   (lane_c[g])
    );
  end

  always_comb begin
    n_o = lane_n[lane_sel];
    v_o = lane_v[lane_sel];
    c_o = lane_c[lane_sel];
    x_o = lane_c[lane_sel];
    z_o = is_ext ? (lane_z[lane_sel] & z_prev_i) : lane_z[lane_sel];
  end

  always_comb begin
    // R8
    if (is_ext && z_o) begin
      ext_z_hold_chk: assert (z_prev_i && (result_o == '0))
        else $error("extended zero flag set without prior zero");
    end
    // R8
    if (is_ext && (result_o != '0)) begin
      ext_z_clear_chk: assert (!z_o)
        else $error("extended zero flag kept on nonzero result");
    end
    // R2
    if (op == OP_ADD) begin
      add_sign_chk: assert (n_o == result_o[DATA_W-1])
        else $error("add negative flag disagrees with result sign");
    end
    // R6
    if ((op == OP_SUBX) && x_i && (opa_i == opb_i)) begin
      subx_equal_chk: assert (c_o && (result_o == '1))
        else $error("extended subtract of equal operands must borrow");
    end
  end

endmodule

// File: tb/tb_ccgen_flag_unit.sv
`timescale 1ns/1ps
module tb_ccgen_flag_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] opa, opb;
  logic [1:0]  op, size;
  logic        xin, zprev;
  logic [31:0] result;
  logic        n, z, v, c, xout;

  int tests_run    = 0;
  int tests_failed = 0;

  typedef struct packed {
    logic [31:0] res;
    logic n, z, v, c, x;
  } exp_t;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  ccgen_flag_unit dut (
    .opa_i(opa), .opb_i(opb), .op_i(op), .size_i(size),
    .x_i(xin), .z_prev_i(zprev),
    .result_o(result), .n_o(n), .z_o(z), .v_o(v), .c_o(c), .x_o(xout)
  );

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic [1:0] o, input logic [1:0] s,
                                 input logic xi, input logic zp);
    exp_t e;
    int w;
    logic ext, ci;
    logic [63:0] mask, am, bm;
    longint sa, sb, d, hi, lo;
    logic [32:0] s33;
    ext = o[1];
    ci  = ext & xi;
    w   = 32;
    if (o == 2'd1) w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    mask = (64'd1 << w) - 64'd1;
    am = {32'd0, a} & mask;
    bm = {32'd0, b} & mask;
    sa = longint'(am) - (am[w-1] ? longint'(64'd1 << w) : 64'sd0);
    sb = longint'(bm) - (bm[w-1] ? longint'(64'd1 << w) : 64'sd0);
    hi = longint'(64'd1 << (w-1)) - 1;
    lo = -longint'(64'd1 << (w-1));
    if (o == 2'd0 || o == 2'd2) begin
      s33   = {1'b0, a} + {1'b0, b} + {32'd0, ci};
      e.res = s33[31:0];
      e.c   = s33[32];
      d     = sa + sb + longint'(ci);
    end else begin
      e.res = a - b - {31'd0, ci};
      e.c   = (am < (bm + {63'd0, ci}));
      d     = sa - sb - longint'(ci);
    end
    e.v = (d > hi) || (d < lo);
    e.n = e.res[w-1];
    e.z = (({32'd0, e.res} & mask) == 64'd0);
    if (ext) e.z = e.z & zp;
    e.x = e.c;
    return e;
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o,
                       input logic [1:0] s, input logic xi, input logic zp, input string tag);
    exp_t e, got;
    @(negedge clk);
    opa = a; opb = b; op = o; size = s; xin = xi; zprev = zp;
    #1;
    e   = model(a, b, o, s, xi, zp);
    got = '{result, n, z, v, c, xout};
    tests_run++;
    if (got !== e) begin
      tests_failed++;
      $display("FAIL %s op=%0d sz=%0d a=%h b=%h x=%b zp=%b: actual res=%h nzvcx=%b%b%b%b%b expected res=%h nzvcx=%b%b%b%b%b",
               tag, o, s, a, b, xi, zp, got.res, got.n, got.z, got.v, got.c, got.x,
               e.res, e.n, e.z, e.v, e.c, e.x);
    end
  endtask

  function automatic string tag_for(input logic [1:0] o);
    case (o)
      2'd0: return "R1/R2";
      2'd1: return "R3/R4/R5";
      2'd2: return "R7/R8";
      default: return "R6/R8";
    endcase
  endfunction

  task automatic t_idle();
    apply(32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 1'b0, "R2 idle zero");
  endtask

  task automatic t_add();
    apply(32'h1, 32'h1, 2'd0, 2'd2, 1'b0, 1'b0, "R1");
    apply(32'h7FFFFFFF, 32'h1, 2'd0, 2'd2, 1'b0, 1'b0, "R2 overflow");
    apply(32'hFFFFFFFF, 32'h1, 2'd0, 2'd2, 1'b0, 1'b0, "R1 carry");
    apply(32'h80000000, 32'h80000000, 2'd0, 2'd2, 1'b0, 1'b0, "R2 neg overflow");
  endtask

  task automatic t_sub_sizes();
    for (int s = 0; s < 4; s++) begin
      apply(32'h00000100, 32'h1, 2'd1, 2'(s), 1'b0, 1'b0, "R3 borrow by width");
      apply(32'h12340080, 32'h00000001, 2'd1, 2'(s), 1'b0, 1'b0, "R4 byte overflow");
      apply(32'h00008000, 32'h00000001, 2'd1, 2'(s), 1'b0, 1'b0, "R4 half overflow");
      apply(32'hABCD1200, 32'h00001200, 2'd1, 2'(s), 1'b0, 1'b0, "R5 low zero");
    end
  endtask

  task automatic t_size_ignored();
    apply(32'h000000FF, 32'h1, 2'd0, 2'd0, 1'b0, 1'b0, "R5 add ignores size");
    apply(32'h00000100, 32'h1, 2'd3, 2'd0, 1'b0, 1'b0, "R5 subx ignores size");
    apply(32'h0000FFFF, 32'h1, 2'd2, 2'd1, 1'b0, 1'b1, "R5 addx ignores size");
  endtask

  task automatic t_subx();
    apply(32'h5, 32'h5, 2'd3, 2'd2, 1'b1, 1'b1, "R6 equal borrow");
    apply(32'h5, 32'h5, 2'd3, 2'd2, 1'b0, 1'b1, "R6 equal no x");
    apply(32'h6, 32'h5, 2'd3, 2'd2, 1'b1, 1'b1, "R6 result zero");
    apply(32'h80000000, 32'h0, 2'd3, 2'd2, 1'b1, 1'b0, "R6 overflow");
  endtask

  task automatic t_addx();
    apply(32'hFFFFFFFF, 32'h0, 2'd2, 2'd2, 1'b1, 1'b1, "R7 wrap");
    apply(32'hFFFFFFFF, 32'h0, 2'd2, 2'd2, 1'b0, 1'b1, "R7 no x");
    apply(32'h7FFFFFFF, 32'h0, 2'd2, 2'd2, 1'b1, 1'b0, "R7 overflow");
  endtask

  task automatic t_zero_sticky();
    apply(32'h0, 32'h0, 2'd2, 2'd2, 1'b0, 1'b0, "R8 zero cannot set");
    apply(32'h0, 32'h0, 2'd2, 2'd2, 1'b0, 1'b1, "R8 zero holds");
    apply(32'h1, 32'h0, 2'd3, 2'd2, 1'b0, 1'b1, "R8 nonzero clears");
    apply(32'h0, 32'h0, 2'd0, 2'd2, 1'b0, 1'b0, "R8 plain add ignores zprev");
    apply(32'h3, 32'h3, 2'd1, 2'd2, 1'b0, 1'b0, "R8 plain sub ignores zprev");
  endtask

  task automatic t_x_ignored();
    apply(32'hFFFFFFFF, 32'h0, 2'd0, 2'd2, 1'b1, 1'b0, "R9 add ignores x");
    apply(32'h5, 32'h5, 2'd1, 2'd2, 1'b1, 1'b0, "R9 sub ignores x");
    apply(32'h00000005, 32'h5, 2'd1, 2'd0, 1'b1, 1'b1, "R9 byte sub ignores x");
  endtask

  task automatic t_boundary();
    logic [31:0] bv [4];
    bv[0] = 32'h0; bv[1] = 32'h7FFFFFFF; bv[2] = 32'h80000000; bv[3] = 32'hFFFFFFFF;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int o = 0; o < 4; o++)
          for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
              apply(bv[i], bv[j], 2'(o), 2'(s), k[0], k[1], tag_for(2'(o)));
  endtask

  task automatic t_random();
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      apply($urandom, $urandom, o, 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), tag_for(o));
    end
  endtask

  initial begin
    #(5.0 * 100000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    opa = '0; opb = '0; op = '0; size = '0; xin = 1'b0; zprev = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub_sizes();
    t_size_ignored();
    t_subx();
    t_addx();
    t_zero_sticky();
    t_x_ignored();
    t_boundary();
    t_random();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule